// File: doc/BRIEF.md
# Clock Root Generator with Staged Source and Half-Step Divider

This block produces one root clock from a set of independent input clocks. It picks one input through a switch that cannot glitch and then divides that input by a ratio in steps of one half. Software programs the block through a small register window that holds two 32-bit words: a command word and a configuration word. The register side runs on its own bus clock, separate from every source clock.

Software writes a new source number and divider code into the configuration word. Those values are only staged there, and the running clock keeps its old setting. The new setting takes effect when software writes 1 to the commit bit of the command word. Hardware then stops the old branch on that clock's falling edge and waits for a synchronised acknowledgement. It loads the staged values, starts the new branch on that clock's falling edge, and clears the commit bit once the new branch reports that it is running. The command word also shows a dirty flag, set while the staged and active settings differ, and a root-off flag. For a divider code d the output frequency is 2·f_in/(d+1). Code 0 passes the chosen source through undivided.

Top module: `clk_root_gen`

## Requirements
- R1: After reset, both words read with all defined fields at 0: source 0, divider code 0 (bypass), commit 0 and dirty 0. Root-off (command bit 31) reads 0 within 10 bus cycles, and the root clock then has the period of source 0.
- R2: The command word is at byte offset 0x0. Bit 0 is commit, bit 4 is dirty and bit 31 is root-off. The configuration word is at offset 0x4, with the source field at bits [SEL_LSB +: clog2(NUM_SRC)] (default bits 9:8) and the divider field at bits [DIV_LSB +: DIV_W] (default bits 4:0). All other bits read 0 and ignore writes. A read of the configuration word returns the staged values.
- R3: A write to the configuration word does not change the root clock until a commit has completed.
- R4: Dirty reads 1 exactly when the staged source or divider differs from the active one. It reads 0 after a commit completes, and also after the staged values are written back to equal the active ones.
- R5: Writing 1 to command bit 0 starts a commit, and the bit reads 1 until the switch has finished. Writing 0 to that bit has no effect. Hardware clears the bit only once the new branch is running, with root-off at 0.
- R6: With divider code d ≥ 1, the root clock period equals (d+1)/2 periods of the selected source.
- R7: With divider code 0, the root clock equals the selected source undivided.
- R8: No high or low phase of the root clock is shorter than half a period of the selected source, including for even codes (half-step ratios).
- R9: At most one source branch is enabled at any time. During a switch there is a gap in which no branch runs, and root-off reads 1 during that gap.
- R10: A commit completes within 64 bus cycles when no source is slower than half the bus clock rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Synchronous active-low reset, held for several cycles of every clock |
| src_clk | input | NUM_SRC | Candidate source clocks |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge of clk |
| bus_addr | input | ADDR_W | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| root_clk | output | 1 | Generated root clock |

## Verification
The bench measures the root clock's period and its high and low phases for bypass, whole ratios and half-step ratios, including the largest code. A divider that miscounts half periods shows up as a wrong period or as a pulse shorter than half a source period. The bench also checks that staged writes, and writes of 0 to the commit bit, leave the measured period unchanged; a design that applied settings early would change the clock there. While a commit is in progress the bench polls the command word. It checks that a stopped gap (root-off 1) is seen, that commit clears within the bound and that dirty then falls, which catches a switch that overlaps branches or never finishes.

// File: rtl/clk_root_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the clock root generator.
// Assumes byte addressing of a window holding two 32-bit words.
package clk_root_pkg;

    localparam int REG_W          = 32;
    localparam int CMD_OFFSET     = 0;
    localparam int CFG_OFFSET     = 4;
    localparam int CMD_COMMIT_BIT = 0;
    localparam int CMD_DIRTY_BIT  = 4;
    localparam int CMD_OFF_BIT    = 31;

    // Switch sequence: idle, stopping the old branch, starting the new one.
    typedef enum logic [1:0] {
        SW_IDLE   = 2'd0,
        SW_DRAIN  = 2'd1,
        SW_LAUNCH = 2'd2
    } sw_state_t;

endpackage

// File: rtl/clk_root_regs.sv
`timescale 1ns/1ps
// Register window and switch sequencer, running on the bus clock.
// It holds the staged and active configuration and walks through
// drain -> load -> launch when software commits.
// Assumes en_ack is already synchronised into the bus clock domain.
module clk_root_regs
    import clk_root_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 2,
    parameter int SEL_LSB = 8,
    parameter int DIV_W   = 5,
    parameter int DIV_LSB = 0,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0] en_ack,
    output logic [NUM_SRC-1:0] en_req,
    output logic [SEL_W-1:0]   act_sel,
    output logic [DIV_W-1:0]   act_div,
    output logic               busy,
    output logic               root_off
);

    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(CMD_OFFSET);
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(CFG_OFFSET);

    logic [SEL_W-1:0] stg_sel;
    logic [DIV_W-1:0] stg_div;
    sw_state_t        state;
    logic             wr_cmd, wr_cfg, dirty;
    logic [REG_W-1:0] cmd_word, cfg_word;

    assign wr_cmd = bus_wr && (bus_addr == A_CMD);
    assign wr_cfg = bus_wr && (bus_addr == A_CFG);

    // Staged configuration: updated by bus writes, fields only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_sel <= '0;
            stg_div <= '0;
        end else if (wr_cfg) begin
            stg_sel <= bus_wdata[SEL_LSB +: SEL_W];
            stg_div <= bus_wdata[DIV_LSB +: DIV_W];
        end
    end

    // Switch sequencer: stop all branches, load staged values, start new one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SW_IDLE;
            act_sel <= '0;
            act_div <= '0;
        end else begin
            case (state)
                SW_IDLE: begin
                    if (wr_cmd && bus_wdata[CMD_COMMIT_BIT]) state <= SW_DRAIN;
                end
                SW_DRAIN: begin
                    if (en_ack == '0) begin
                        act_sel <= stg_sel;
                        act_div <= stg_div;
                        state   <= SW_LAUNCH;
                    end
                end
                SW_LAUNCH: begin
                    if (en_ack[act_sel]) state <= SW_IDLE;
                end
                default: state <= SW_IDLE;
            endcase
        end
    end

    // Branch requests: only the active source, and none while draining.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            en_req[i] = (state != SW_DRAIN) && (act_sel == SEL_W'(i));
        end
    end

    assign busy     = (state != SW_IDLE);
    assign dirty    = (stg_sel != act_sel) || (stg_div != act_div);
    assign root_off = (en_ack == '0);

    // Read words assembled from status and staged fields.
    always_comb begin
        cmd_word                 = '0;
        cmd_word[CMD_COMMIT_BIT] = busy;
        cmd_word[CMD_DIRTY_BIT]  = dirty;
        cmd_word[CMD_OFF_BIT]    = root_off;
        cfg_word                 = '0;
        cfg_word[SEL_LSB +: SEL_W] = stg_sel;
        cfg_word[DIV_LSB +: DIV_W] = stg_div;
        if (bus_addr == A_CFG)      bus_rdata = cfg_word;
        else if (bus_addr == A_CMD) bus_rdata = cmd_word;
        else                        bus_rdata = '0;
    end

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

endmodule

// File: rtl/clk_root_gfmux.sv
`timescale 1ns/1ps
// Glitch-free source switch. Each branch synchronises its enable
// request into its own clock and changes its gate only on that clock's
// falling edge. It then reports the gate state back to the bus clock
// through two flops. Branch 0 comes out of reset enabled.
// Assumes the sequencer never requests two branches at once.
module clk_root_gfmux #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_clk,
    input  logic [NUM_SRC-1:0] en_req,
    output logic [NUM_SRC-1:0] en_live,
    output logic [NUM_SRC-1:0] en_ack,
    output logic               mclk
);

    logic [NUM_SRC-1:0] gated;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_branch
        localparam logic RST_EN = (g == 0);
        logic s1, s2, gate_q, a1, a2;

        // Bring the enable request into this source's domain.
        always_ff @(posedge src_clk[g]) begin
            if (!rst_n) begin
                s1 <= RST_EN;
                s2 <= RST_EN;
            end else begin
                s1 <= en_req[g];
                s2 <= s1;
            end
        end

        // Change the gate only while the source is low.
        always_ff @(negedge src_clk[g]) begin
            if (!rst_n) gate_q <= RST_EN;
            else        gate_q <= s2;
        end

        // Return the gate state to the bus domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a1 <= 1'b0;
                a2 <= 1'b0;
            end else begin
                a1 <= gate_q;
                a2 <= a1;
            end
        end

        assign gated[g]   = src_clk[g] & gate_q;
        assign en_live[g] = gate_q;
        assign en_ack[g]  = a2;
    end

    assign mclk = |gated;

endmodule

// File: rtl/clk_root_hdiv.sv
`timescale 1ns/1ps
// Half-step divider. For code d the output period is P = d+1 half
// periods of mclk. A counter runs modulo P source cycles, which spans
// two output periods. The output changes at half-period times
// {0, H, P, P+H}, with H = ceil(P/2). Even times are rising-edge toggles
// and odd times are falling-edge toggles, so every phase is at least
// one half period of mclk. Code 0 bypasses the divider.
// Assumes div_val only changes while mclk is stopped.
module clk_root_hdiv #(
    parameter int DIV_W = 5
) (
    input  logic             mclk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             dclk
);

    localparam int TW = DIV_W + 2;

    logic [TW-1:0] span, high_len, ev1, ev2, ev3;
    logic [TW-2:0] cnt, cnt_nxt;
    logic [TW-1:0] t_rise, t_fall;
    logic          hit_rise, hit_fall, tog_r, tog_f;

    assign span     = TW'(div_val) + TW'(1);
    assign high_len = (span + TW'(1)) >> 1;
    assign ev1      = high_len;
    assign ev2      = span;
    assign ev3      = span + high_len;

    assign cnt_nxt  = (TW'(cnt) + TW'(1) >= span) ? '0 : cnt + 1'b1;
    assign t_rise   = {cnt_nxt, 1'b0};
    assign t_fall   = {cnt, 1'b1};
    assign hit_rise = (t_rise == '0) || (t_rise == ev1) || (t_rise == ev2) || (t_rise == ev3);
    assign hit_fall = (t_fall == ev1) || (t_fall == ev2) || (t_fall == ev3);

    // Rising-edge half: cycle counter and even-time toggle.
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            cnt   <= '0;
            tog_r <= 1'b0;
        end else begin
            cnt   <= cnt_nxt;
            tog_r <= tog_r ^ hit_rise;
        end
    end

    // Falling-edge half: odd-time toggle.
    always_ff @(negedge mclk) begin
        if (!rst_n) tog_f <= 1'b0;
        else        tog_f <= tog_f ^ hit_fall;
    end

    assign dclk = (div_val == '0) ? mclk : (tog_r ^ tog_f);

endmodule

// File: rtl/clk_root_gen.sv
`timescale 1ns/1ps
// Clock root generator top. It joins the register sequencer, the
// glitch-free switch and the half-step divider.
// Assumes NUM_SRC >= 2 and that software selects only existing sources.
module clk_root_gen
    import clk_root_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int SEL_LSB = 8,
    parameter int DIV_W   = 5,
    parameter int DIV_LSB = 0,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_clk,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    output logic               root_clk
);

    localparam int SEL_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] en_req, en_ack, en_live;
    logic [SEL_W-1:0]   act_sel;
    logic [DIV_W-1:0]   act_div;
    logic               busy, root_off, mclk;

    clk_root_regs #(
        .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .SEL_LSB(SEL_LSB),
        .DIV_W(DIV_W), .DIV_LSB(DIV_LSB), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .en_ack(en_ack),
        .en_req(en_req), .act_sel(act_sel), .act_div(act_div),
        .busy(busy), .root_off(root_off)
    );

    clk_root_gfmux #(.NUM_SRC(NUM_SRC)) u_mux (
        .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .en_req(en_req),
        .en_live(en_live), .en_ack(en_ack), .mclk(mclk)
    );

    clk_root_hdiv #(.DIV_W(DIV_W)) u_div (
        .mclk(mclk), .rst_n(rst_n), .div_val(act_div), .dclk(root_clk)
    );

endmodule

// File: rtl/clk_root_chk.sv
`timescale 1ns/1ps
// Protocol checker for the clock root generator, bound to the top.
// It watches the sequencer and the branch gates on the bus clock.
module clk_root_chk
    import clk_root_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 2,
    parameter int DIV_W   = 5,
    parameter int ADDR_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [REG_W-1:0]   bus_wdata,
    input logic               busy,
    input logic               root_off,
    input logic [SEL_W-1:0]   act_sel,
    input logic [DIV_W-1:0]   act_div,
    input logic [NUM_SRC-1:0] en_live
);

    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(CMD_OFFSET);

    // R5: writing 1 to the commit bit while idle starts a commit.
    assert_commit_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CMD && bus_wdata[CMD_COMMIT_BIT] && !busy) |=> busy);

    // R5: writing 0 to the commit bit while idle leaves it clear.
    assert_zero_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CMD && !bus_wdata[CMD_COMMIT_BIT] && !busy) |=> !busy);

    // R5: the commit bit clears only once the new branch runs.
    assert_clear_when_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !root_off);

    // R3: the active configuration holds outside a commit.
    assert_active_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> ($stable(act_sel) && $stable(act_div)));

    // R9: never two branch gates open at once.
    assert_single_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en_live));

endmodule

bind clk_root_gen clk_root_chk #(
    .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .root_off(root_off),
    .act_sel(act_sel), .act_div(act_div), .en_live(en_live)
);

// File: tb/tb_clk_root_gen.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected root period, and the
// monitor measures the clock and compares.
module tb_clk_root_gen;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_CMD = 3'd0;
    localparam logic [2:0] A_CFG = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_clk = 4'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        root_clk;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    typedef struct { int per; int half; string tag; } exp_t;
    exp_t exp_q[$];
    bit mon_busy = 1'b0;

    clk_root_gen dut (
        .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .root_clk(root_clk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    initial forever #4  src_clk[0] = ~src_clk[0];
    initial forever #6  src_clk[1] = ~src_clk[1];
    initial forever #10 src_clk[2] = ~src_clk[2];
    initial forever #3  src_clk[3] = ~src_clk[3];

    function automatic int src_per(int s);
        case (s)
            0: return 8;
            1: return 12;
            2: return 20;
            default: return 6;
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic bus_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Driver side: queue an expectation and wait for the monitor.
    task automatic expect_clock(int s, int d, string tag);
        exp_t it;
        it.per  = (d == 0) ? src_per(s) : src_per(s) * (d + 1) / 2;
        it.half = src_per(s) / 2;
        it.tag  = tag;
        exp_q.push_back(it);
        #1;
        wait (exp_q.size() == 0 && !mon_busy);
    endtask

    // Monitor: measure one root period and its phases.
    initial forever begin
        exp_t it;
        real t0, t1, t2;
        int per, hi, lo;
        wait (exp_q.size() > 0);
        mon_busy = 1'b1;
        it = exp_q.pop_front();
        repeat (3) @(posedge root_clk);
        t0 = $realtime;
        @(negedge root_clk);
        t1 = $realtime;
        @(posedge root_clk);
        t2 = $realtime;
        per = int'(t2 - t0);
        hi  = int'(t1 - t0);
        lo  = int'(t2 - t1);
        check(per == it.per, it.tag, "root period", per, it.per);
        check(hi >= it.half && lo >= it.half, "R8", "shortest phase",
              (hi < lo) ? hi : lo, it.half);
        mon_busy = 1'b0;
    end

    // Commit and poll: returns cycles taken and whether root-off was seen.
    task automatic commit(output int cyc, output bit seen_off);
        logic [31:0] w;
        cyc = 999;
        seen_off = 1'b0;
        bus_write(A_CMD, 32'h1);
        for (int k = 0; k < 300; k++) begin
            bus_read(A_CMD, w);
            if (w[31]) seen_off = 1'b1;
            if (!w[0]) begin
                cyc = k;
                break;
            end
        end
    endtask

    task automatic switch_to(int s, int d, string tag);
        logic [31:0] w;
        int cyc;
        bit seen;
        bus_write(A_CFG, (32'(s) << 8) | 32'(d));
        bus_read(A_CFG, w);
        check(w == ((32'(s) << 8) | 32'(d)), "R2", "staged cfg readback", w, (s << 8) | d);
        commit(cyc, seen);
        check(cyc <= 64, "R10", "commit cycles", cyc, 64);
        check(seen, "R9", "root-off gap seen", seen, 1);
        bus_read(A_CMD, w);
        check(w[4] == 1'b0, "R4", "dirty after commit", w[4], 0);
        check(w[31] == 1'b0, "R5", "root-off after commit", w[31], 0);
        expect_clock(s, d, tag);
    endtask

    initial begin
        logic [31:0] w;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        bus_read(A_CMD, w);
        check(w[0] == 1'b0 && w[4] == 1'b0, "R1", "cmd after reset", w & 32'h11, 0);
        bus_read(A_CFG, w);
        check(w == 32'h0, "R1", "cfg after reset", w, 0);
        repeat (10) @(negedge clk);
        bus_read(A_CMD, w);
        check(w[31] == 1'b0, "R1", "root-off after reset", w[31], 0);
        expect_clock(0, 0, "R1");

        // R2: only the field bits are kept.
        bus_write(A_CFG, 32'hFFFF_FFFF);
        bus_read(A_CFG, w);
        check(w == 32'h0000_031F, "R2", "cfg field mask", w, 32'h31F);
        bus_read(A_CMD, w);
        check(w[4] == 1'b1, "R4", "dirty after differing write", w[4], 1);
        bus_write(A_CFG, 32'h0);
        bus_read(A_CMD, w);
        check(w[4] == 1'b0, "R4", "dirty after restoring active", w[4], 0);

        // R3: staged values have no effect before commit.
        bus_write(A_CFG, 32'h0000_0102);
        bus_read(A_CMD, w);
        check(w[4] == 1'b1, "R4", "dirty with staged change", w[4], 1);
        expect_clock(0, 0, "R3");

        // R5: writing 0 to commit does nothing.
        bus_write(A_CMD, 32'h0);
        bus_read(A_CMD, w);
        check(w[0] == 1'b0, "R5", "commit after zero write", w[0], 0);
        expect_clock(0, 0, "R5");

        switch_to(1, 0, "R7");
        switch_to(0, 3, "R6");
        switch_to(2, 2, "R8");
        switch_to(3, 4, "R8");
        switch_to(1, 1, "R6");
        switch_to(3, 31, "R6");
        switch_to(2, 6, "R8");
        switch_to(0, 0, "R7");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule